// File: doc/BRIEF.md
# Pattern-Replay CCD Clock Sequencer

This block produces the digital clock waveforms used to read out a group of CCDs. The waveforms are not hard-coded. A host first loads a pattern memory, in which every bit of a word sets one clock line high (1) or low (0) for one time step. The sequencer then plays the stored words back to a parallel clock bus in a fixed loop structure. Each frame line first replays a vertical-transfer segment once. It then replays a horizontal-transfer segment for every pixel, and within each pixel for every CCD in turn. A CCD-select output names the device being served.

The pattern memory is reached through one address unit. While the host downloads, it drives the memory from an auto-incrementing write pointer. During playback it drives the memory from the sequencer's segment offsets. The segment placement and size, the pixel and line counts and the number of CCDs are captured from the configuration inputs when a frame starts. The host can therefore prepare the next frame while the current one runs.

Top module: `ccd_seq_top`

## Requirements
- R1: After a synchronous active-low reset, `clk_out` and `ccd_sel` are all zero and `busy` and `done` are low.
- R2: A `host_load` pulse sets the download pointer to `host_addr`. With `dl_mode` high and the sequencer idle, each cycle with `host_we` high stores `host_data` at the pointer and then advances the pointer by one, wrapping modulo the memory depth.
- R3: Writes with `dl_mode` low, and start requests with `dl_mode` high, have no effect on memory contents or on the sequencer.
- R4: After a start, each line replays the vertical segment once and then the horizontal segment for every CCD of every pixel. The vertical segment covers words `v_start + i` for i = 0 … `v_len_m1`. The horizontal segment covers words `h_start + i` for i = 0 … `h_len_m1`. Addresses wrap modulo the depth. This whole pattern repeats for `lines` lines of `pixels` pixels.
- R5: The stored word read for a step appears on `clk_out` in the second cycle after the edge that leaves idle, and in the following steps it advances one word per clock. Bit k of the word drives `clk_out[k]`.
- R6: `ccd_sel` counts 0 … `nccd_m1` (1 to 32 CCDs), stepping once per completed horizontal segment. The pixel count advances only after the last CCD. `ccd_sel` is 0 during vertical segments and while idle.
- R7: One cycle after the last word of a frame is shown, `clk_out` returns to zero, `busy` falls and `done` rises. `done` stays high until the next accepted start or an abort.
- R8: A start with `pixels` or `lines` equal to zero shows no word. `done` is high and `busy` is low from the clock after the start.
- R9: `abort` high at a clock edge returns the sequencer to idle at that edge. From that edge on, `clk_out` and `ccd_sel` are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Synchronous return to idle |
| dl_mode | input | 1 | Download mode enable |
| host_load | input | 1 | Load the download pointer from `host_addr` |
| host_addr | input | ADDR_W | Download start address |
| host_we | input | 1 | Write strobe for one pattern word |
| host_data | input | LINES | Pattern word to store |
| start | input | 1 | Start a frame (ignored in download mode or when busy) |
| v_start | input | ADDR_W | First word of the vertical segment |
| v_len_m1 | input | ADDR_W | Vertical segment length minus one |
| h_start | input | ADDR_W | First word of the horizontal segment |
| h_len_m1 | input | ADDR_W | Horizontal segment length minus one |
| pixels | input | CNT_W | Pixels per line |
| lines | input | CNT_W | Lines per frame |
| nccd_m1 | input | SEL_W | Number of CCDs minus one |
| clk_out | output | LINES | Clock line levels |
| ccd_sel | output | SEL_W | CCD currently served |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished |

## Verification
The bench keeps a queue model of the expected word stream and compares it on every clock. It uses four kinds of frame. A frame of several lines with a single CCD tests the vertical-then-horizontal nesting and the line repeat. A frame of three CCDs whose segment crosses the top address tests the CCD multiplexing and the address wrap. A frame of 32 CCDs tests the widest select range. A short frame over freshly downloaded words at a reloaded pointer shows whether the pointer load and the auto-increment landed where intended. Zero-count starts, an abort partway through a frame and writes or starts in the wrong mode separate the early-exit and ignore paths from normal playback.

// File: rtl/ccd_seq_pkg.sv
// Package: shared state encoding for the CCD clock sequencer.
// Assumes: imported by the controller and the top module.
package ccd_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_VSEG = 2'd1,
        S_HSEG = 2'd2,
        S_FIN  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ccd_pat_ram.sv
// Module: single-port synchronous pattern memory with a registered read.
// Assumes: a write and a read never coincide in the same cycle (the address
// unit only writes while idle). Read data is valid one clock after the address.
module ccd_pat_ram #(
    parameter int LINES  = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    output logic [LINES-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LINES-1:0] mem [DEPTH];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[addr];
    end
endmodule

// File: rtl/ccd_addr_unit.sv
// Module: the one address controller of the pattern memory. It holds the
// host download pointer and picks between that pointer and the playback
// address. Assumes: playback and download never overlap (writes need idle).
module ccd_addr_unit #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_mode,
    input  logic              host_load,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic              busy,
    input  logic              issue,
    input  logic [ADDR_W-1:0] play_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we
);
    logic [ADDR_W-1:0] ptr_q;
    logic              wr_ok;

    // A host write is accepted only in download mode with the sequencer idle.
    assign wr_ok    = dl_mode && host_we && !busy;
    assign mem_we   = wr_ok;
    assign mem_addr = issue ? play_addr : ptr_q;

    // Download pointer: load from the host, else step after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_q <= '0;
        else if (host_load) ptr_q <= host_addr;
        else if (wr_ok)     ptr_q <= ptr_q + 1'b1;
    end

    // R2: an accepted write without a load advances the pointer by exactly one.
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !host_load) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R3: no memory write happens outside download mode.
    p_no_write_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_mode |-> !mem_we);
endmodule

// File: rtl/ccd_seq_ctrl.sv
// Module: frame sequencer. It captures the configuration at start and walks
// lines -> (vertical segment, pixels -> CCDs -> horizontal segment). For each
// step it issues one memory address. Assumes: length and CCD fields are minus-one
// encoded; a zero pixel or line count ends the frame at once.
module ccd_seq_ctrl
    import ccd_seq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic              dl_mode,
    input  logic [ADDR_W-1:0] v_start,
    input  logic [ADDR_W-1:0] v_len_m1,
    input  logic [ADDR_W-1:0] h_start,
    input  logic [ADDR_W-1:0] h_len_m1,
    input  logic [CNT_W-1:0]  pixels,
    input  logic [CNT_W-1:0]  lines,
    input  logic [SEL_W-1:0]  nccd_m1,
    output logic              issue,
    output logic [ADDR_W-1:0] play_addr,
    output logic [SEL_W-1:0]  issue_sel,
    output logic              busy,
    output logic              done
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] vs_r, vl_r, hs_r, hl_r, idx_q;
    logic [CNT_W-1:0]  pix_r, lin_r, pix_q, lin_q;
    logic [SEL_W-1:0]  nc_r, ccd_q;
    logic [CNT_W-1:0]  pix_last, lin_last;
    logic              zero_cnt;

    assign pix_last  = pix_r - CNT_W'(1);
    assign lin_last  = lin_r - CNT_W'(1);
    assign zero_cnt  = (pixels == '0) || (lines == '0);
    assign issue     = (state_q == S_VSEG) || (state_q == S_HSEG);
    assign play_addr = ((state_q == S_VSEG) ? vs_r : hs_r) + idx_q;
    assign issue_sel = (state_q == S_HSEG) ? ccd_q : '0;
    assign busy      = (state_q != S_IDLE);

    // Configuration capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_r <= '0; vl_r <= '0; hs_r <= '0; hl_r <= '0;
            pix_r <= '0; lin_r <= '0; nc_r <= '0;
        end else if (state_q == S_IDLE && start && !dl_mode && !abort) begin
            vs_r <= v_start; vl_r <= v_len_m1;
            hs_r <= h_start; hl_r <= h_len_m1;
            pix_r <= pixels; lin_r <= lines; nc_r <= nccd_m1;
        end
    end

    // Loop state machine and nested counters.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= S_IDLE; done <= 1'b0;
            idx_q <= '0; ccd_q <= '0; pix_q <= '0; lin_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start && !dl_mode) begin
                    idx_q <= '0; ccd_q <= '0; pix_q <= '0; lin_q <= '0;
                    done  <= zero_cnt;
                    if (!zero_cnt) state_q <= S_VSEG;
                end
                S_VSEG: if (idx_q == vl_r) begin
                    idx_q   <= '0;
                    state_q <= S_HSEG;
                end else idx_q <= idx_q + 1'b1;
                S_HSEG: if (idx_q != hl_r) idx_q <= idx_q + 1'b1;
                else begin
                    idx_q <= '0;
                    if (ccd_q != nc_r) ccd_q <= ccd_q + 1'b1;
                    else begin
                        ccd_q <= '0;
                        if (pix_q != pix_last) pix_q <= pix_q + 1'b1;
                        else begin
                            pix_q <= '0;
                            if (lin_q == lin_last) state_q <= S_FIN;
                            else begin
                                lin_q   <= lin_q + 1'b1;
                                state_q <= S_VSEG;
                            end
                        end
                    end
                end
                S_FIN: begin
                    state_q <= S_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R9: abort always lands in idle with done low.
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == S_IDLE && !done));

    // R6: the CCD counter never passes the programmed last CCD.
    p_sel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HSEG) |-> (ccd_q <= nc_r));

    // R7: done is only ever shown while idle.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == S_IDLE));

    // R8: a zero-count start raises done on the next clock.
    p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && !dl_mode && !abort && zero_cnt) |=> done);

    // R3: a start in download mode leaves the sequencer idle.
    p_dl_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && dl_mode && !abort) |=> (state_q == S_IDLE));
endmodule

// File: rtl/ccd_seq_top.sv
// Module: top of the CCD clock sequencer. It ties the pattern memory, the
// shared address unit and the frame controller together, and aligns the
// CCD select with the one-cycle memory read latency.
// Assumes: clk_out is forced to zero whenever no playback word is valid.
module ccd_seq_top
    import ccd_seq_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              dl_mode,
    input  logic              host_load,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [LINES-1:0]  host_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] v_start,
    input  logic [ADDR_W-1:0] v_len_m1,
    input  logic [ADDR_W-1:0] h_start,
    input  logic [ADDR_W-1:0] h_len_m1,
    input  logic [CNT_W-1:0]  pixels,
    input  logic [CNT_W-1:0]  lines,
    input  logic [SEL_W-1:0]  nccd_m1,
    output logic [LINES-1:0]  clk_out,
    output logic [SEL_W-1:0]  ccd_sel,
    output logic              busy,
    output logic              done
);
    logic              issue, mem_we, valid_q;
    logic [ADDR_W-1:0] play_addr, mem_addr;
    logic [SEL_W-1:0]  issue_sel, sel_q;
    logic [LINES-1:0]  rdata;

    ccd_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .abort(abort), .start(start), .dl_mode(dl_mode),
        .v_start(v_start), .v_len_m1(v_len_m1), .h_start(h_start), .h_len_m1(h_len_m1),
        .pixels(pixels), .lines(lines), .nccd_m1(nccd_m1),
        .issue(issue), .play_addr(play_addr), .issue_sel(issue_sel),
        .busy(busy), .done(done)
    );

    ccd_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .dl_mode(dl_mode), .host_load(host_load),
        .host_addr(host_addr), .host_we(host_we), .busy(busy), .issue(issue),
        .play_addr(play_addr), .mem_addr(mem_addr), .mem_we(mem_we)
    );

    ccd_pat_ram #(.LINES(LINES), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
        .wdata(host_data), .rdata(rdata)
    );

    // Output alignment: valid flag and CCD select follow the read by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            valid_q <= 1'b0;
            sel_q   <= '0;
        end else begin
            valid_q <= issue;
            sel_q   <= issue ? issue_sel : '0;
        end
    end

    assign clk_out = valid_q ? rdata : '0;
    assign ccd_sel = sel_q;

    // R7: once done is up, the clock bus is parked at zero.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_out == '0 && ccd_sel == '0));

    // R9: after an abort edge the outputs are silent.
    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (clk_out == '0 && !busy));
endmodule

// File: tb/ccd_seq_top_test.sv
// Bench: behavioural queue model of the frame word stream, compared every clock.
module ccd_seq_top_test;
    localparam int LINES = 8, ADDR_W = 6, CNT_W = 8, SEL_W = 5, DEPTH = 64;

    logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0, dl_mode = 1'b0;
    logic host_load = 1'b0, host_we = 1'b0, start = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0, v_start = '0, v_len_m1 = '0, h_start = '0, h_len_m1 = '0;
    logic [LINES-1:0]  host_data = '0;
    logic [CNT_W-1:0]  pixels = '0, lines = '0;
    logic [SEL_W-1:0]  nccd_m1 = '0;
    logic [LINES-1:0]  clk_out;
    logic [SEL_W-1:0]  ccd_sel;
    logic              busy, done;

    int total = 0, bad = 0, cycles = 0;
    int mdl [DEPTH];
    int ptr = 0;

    always #5 clk = ~clk;

    ccd_seq_top uut (
        .clk(clk), .rst_n(rst_n), .abort(abort), .dl_mode(dl_mode),
        .host_load(host_load), .host_addr(host_addr), .host_we(host_we),
        .host_data(host_data), .start(start), .v_start(v_start), .v_len_m1(v_len_m1),
        .h_start(h_start), .h_len_m1(h_len_m1), .pixels(pixels), .lines(lines),
        .nccd_m1(nccd_m1), .clk_out(clk_out), .ccd_sel(ccd_sel), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_ptr(input int a);
        @(negedge clk); host_load = 1'b1; host_addr = ADDR_W'(a);
        @(negedge clk); host_load = 1'b0;
        ptr = a;
    endtask

    // One write strobe; the model stores only when the write is accepted.
    task automatic write_word(input int d);
        @(negedge clk); host_we = 1'b1; host_data = LINES'(d);
        @(negedge clk); host_we = 1'b0;
        if (dl_mode) begin
            mdl[ptr] = d & 8'hFF;
            ptr = (ptr + 1) % DEPTH;
        end
    endtask

    // Build the expected stream (R4, R6), start, and compare every clock (R5, R7).
    task automatic run_frame(input string tag, input int vs, input int vl, input int hs,
                             input int hl, input int px, input int ln, input int nc);
        int qw[$];
        int qs[$];
        for (int l = 0; l < ln; l++) begin
            for (int i = 0; i < vl; i++) begin qw.push_back(mdl[(vs + i) % DEPTH]); qs.push_back(0); end
            for (int p = 0; p < px; p++)
                for (int c = 0; c < nc; c++)
                    for (int i = 0; i < hl; i++) begin qw.push_back(mdl[(hs + i) % DEPTH]); qs.push_back(c); end
        end
        v_start = ADDR_W'(vs); v_len_m1 = ADDR_W'(vl - 1);
        h_start = ADDR_W'(hs); h_len_m1 = ADDR_W'(hl - 1);
        pixels = CNT_W'(px); lines = CNT_W'(ln); nccd_m1 = SEL_W'(nc - 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({tag, " R5 first cycle blank"}, int'(clk_out), 0);
        chk({tag, " R5 busy"}, int'(busy), 1);
        foreach (qw[k]) begin
            @(negedge clk);
            chk({tag, " R4 word"}, int'(clk_out), qw[k]);
            chk({tag, " R6 sel"}, int'(ccd_sel), qs[k]);
            chk({tag, " R7 busy during frame"}, int'(busy), 1);
            chk({tag, " R7 done low"}, int'(done), 0);
        end
        @(negedge clk);
        chk({tag, " R7 done"}, int'(done), 1);
        chk({tag, " R7 idle"}, int'(busy), 0);
        chk({tag, " R7 quiet"}, int'(clk_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 clk_out", int'(clk_out), 0);
        chk("R1 sel", int'(ccd_sel), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;

        // R2: fill the whole memory from address 0 with auto-increment.
        dl_mode = 1'b1;
        load_ptr(0);
        for (int a = 0; a < DEPTH; a++) write_word((a * 37 + 5) & 8'hFF);
        // R3: a start while in download mode is ignored.
        v_len_m1 = '0; h_len_m1 = '0; pixels = 1; lines = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3 start ignored in download", int'(busy), 0);
        @(negedge clk);
        chk("R3 no output after ignored start", int'(clk_out), 0);
        dl_mode = 1'b0;

        run_frame("F1", 0, 2, 10, 3, 2, 2, 1);
        run_frame("F2 wrap", 62, 1, 63, 2, 2, 1, 3);
        run_frame("F3 32 ccd", 5, 1, 7, 1, 1, 1, 32);

        // R2: reload the pointer and write three new words.
        dl_mode = 1'b1;
        load_ptr(20);
        write_word(8'hA1); write_word(8'h5C); write_word(8'hE7);
        dl_mode = 1'b0;
        // R3: this write is outside download mode and must not land at word 23.
        write_word(8'hFF);
        run_frame("F4 R2 download", 20, 3, 23, 1, 1, 1, 1);

        // R8: zero pixels, then zero lines.
        pixels = 0; lines = 3;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R8 zero pixels done", int'(done), 1);
        chk("R8 zero pixels idle", int'(busy), 0);
        @(negedge clk);
        chk("R8 zero pixels quiet", int'(clk_out), 0);
        pixels = 2; lines = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R8 zero lines done", int'(done), 1);
        chk("R8 zero lines idle", int'(busy), 0);

        // R9: abort part-way through a frame.
        v_start = 0; v_len_m1 = 1; h_start = 8; h_len_m1 = 3;
        pixels = 4; lines = 4; nccd_m1 = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk("R9 abort busy", int'(busy), 0);
        chk("R9 abort done", int'(done), 0);
        chk("R9 abort clk_out", int'(clk_out), 0);
        chk("R9 abort sel", int'(ccd_sel), 0);
        repeat (3) @(negedge clk);
        chk("R9 stays idle", int'(busy), 0);

        run_frame("F5 after abort", 30, 2, 40, 2, 1, 2, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule